// File: doc/BRIEF.md
# Double-Rate Burst-of-Two Synchronous SRAM

This block models a pipelined static RAM whose data bus runs at twice the rate of its main clock. Every access carries a pair of data words for a single address. The two halves of each clock period appear as two separate ports, a rise beat and a fall beat, so the whole design runs in one clock domain. Read and write requests use separate request inputs. The address bus alternates between them: one rising edge of the clock may carry a read address, and the next may carry a write address. Write data follows one cycle after its write address. A read that targets a burst whose write is still in flight receives the new beats through a forwarding path.

A two-state machine tracks the address slots. After reset it is in `SLOT_RD`. On every clock edge it moves from `SLOT_RD` to `SLOT_WR`, or from `SLOT_WR` back to `SLOT_RD`. A one-bit burst index sets the order of the two words. When `WIDE` is 1, the index starts at the address LSB and wraps. When `WIDE` is 0, the index always starts at zero and every address bit selects the burst. Read data leaves through a registered output stage. Setting `OUT_REG` adds one more retiming register, which stands in for launching the data on a separate output clock pair. `q_valid` is the echo strobe that travels with the data.

Top module: `ddrb2_sram`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `q_valid` is 0 and both data outputs are 0.
- R2: The first rising edge after reset release is a read slot, and the slots then alternate read, write, read. A read request on a write slot and a write request on a read slot are ignored.
- R3: Write beats are sampled on the edge after the accepted write address. `wd_rise` is the first word of the burst and `wd_fall` is the second.
- R4: A read accepted at edge N sets `q_valid` for exactly one cycle after edge N+1, or after edge N+2 when `OUT_REG`=1. `q_rise` then holds the first word and `q_fall` the second.
- R5: With `WIDE`=1, `addr[AW-1:1]` selects the burst and `addr[0]` is the starting word index. When the start index is 1, the rise beat is word 1 and the fall beat wraps to word 0.
- R6: With `WIDE`=0, the burst always starts at word 0, and all `AW` address bits select the burst, so addresses that differ only in bit 0 are distinct bursts.
- R7: A read accepted on the edge after a write address to the same burst returns the new write beats, not the stored ones.
- R8: Whenever `q_valid` is 0, `q_rise` and `q_fall` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; both beats of a period are handled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, honoured only in a read slot |
| wr_req | input | 1 | Write request, honoured only in a write slot |
| addr | input | AW | Shared read/write burst address |
| wd_rise | input | DW | First-half write beat |
| wd_fall | input | DW | Second-half write beat |
| q_rise | output | DW | First-half read beat |
| q_fall | output | DW | Second-half read beat |
| q_valid | output | 1 | Echo strobe marking valid read beats |

## Verification
The assertions assume that requests respect the slot pattern. They also assume that reads land no more often than every second cycle, which the slot machine guarantees. The only thing the environment must supply for this is a clean reset release. The stimulus releases reset between clock edges, so the first edge the bench drives is known to be a read slot. Requests are placed on purpose both in and out of their slots. Write beats are always driven on the cycle after the write address, as the interface requires. The bench reads only bursts that it has written earlier, so uninitialised storage is never compared.

// File: rtl/ddrb2_pkg.sv
package ddrb2_pkg;
    typedef enum logic {
        SLOT_RD = 1'b0,
        SLOT_WR = 1'b1
    } slot_e;
endpackage

// File: rtl/ddrb2_slot_fsm.sv
module ddrb2_slot_fsm
    import ddrb2_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot,
    output logic  rd_slot,
    output logic  wr_slot
);
    slot_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_RD;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_RD: state_d = SLOT_WR;
            SLOT_WR: state_d = SLOT_RD;
        endcase
    end

    always_comb begin
        slot    = state_q;
        rd_slot = (state_q == SLOT_RD);
        wr_slot = (state_q == SLOT_WR);
    end

    // R2: address slots strictly alternate
    a_r2_slot_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (state_q != $past(state_q)));
endmodule

// File: rtl/ddrb2_burst_map.sv
module ddrb2_burst_map #(
    parameter int AW   = 4,
    parameter bit WIDE = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] pair,
    output logic          start
);
    generate
        if (WIDE) begin : g_wide
            assign pair  = {1'b0, addr[AW-1:1]};
            assign start = addr[0];
        end else begin : g_narrow
            assign pair  = addr;
            assign start = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/ddrb2_out_stage.sv
module ddrb2_out_stage #(
    parameter int DW      = 8,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_r,
    input  logic [DW-1:0] in_f,
    output logic          out_vld,
    output logic [DW-1:0] out_r,
    output logic [DW-1:0] out_f
);
    localparam int NST = OUT_REG ? 2 : 1;

    logic          vq [NST];
    logic [DW-1:0] rq [NST];
    logic [DW-1:0] fq [NST];

    generate
        for (genvar s = 0; s < NST; s++) begin : g_st
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vq[0] <= 1'b0;
                        rq[0] <= '0;
                        fq[0] <= '0;
                    end else begin
                        vq[0] <= in_vld;
                        rq[0] <= in_vld ? in_r : '0;
                        fq[0] <= in_vld ? in_f : '0;
                    end
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        vq[s] <= 1'b0;
                        rq[s] <= '0;
                        fq[s] <= '0;
                    end else begin
                        vq[s] <= vq[s-1];
                        rq[s] <= rq[s-1];
                        fq[s] <= fq[s-1];
                    end
                end
            end
        end
    endgenerate

    assign out_vld = vq[NST-1];
    assign out_r   = rq[NST-1];
    assign out_f   = fq[NST-1];
endmodule

// File: rtl/ddrb2_sram.sv
module ddrb2_sram
    import ddrb2_pkg::*;
#(
    parameter int DW      = 8,
    parameter int AW      = 4,
    parameter bit WIDE    = 1'b1,
    parameter bit OUT_REG = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          wr_req,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wd_rise,
    input  logic [DW-1:0] wd_fall,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall,
    output logic          q_valid
);
    localparam int IW    = AW + 1;
    localparam int WORDS = 2 ** IW;

    slot_e         slot;
    logic          rd_slot, wr_slot;
    logic [AW-1:0] in_pair;
    logic          in_start;

    ddrb2_slot_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot    (slot),
        .rd_slot (rd_slot),
        .wr_slot (wr_slot)
    );

    ddrb2_burst_map #(.AW(AW), .WIDE(WIDE)) u_map (
        .addr  (addr),
        .pair  (in_pair),
        .start (in_start)
    );

    logic rd_ok, wr_ok;
    assign rd_ok = rd_slot && rd_req && (slot == SLOT_RD);
    assign wr_ok = wr_slot && wr_req;

    // read address register
    logic          rv;
    logic [AW-1:0] r_pair;
    logic          r_start;
    // write address register
    logic          wa_vld;
    logic [AW-1:0] wa_pair;
    logic          wa_start;
    // write data register (pending commit)
    logic          wd_vld;
    logic [AW-1:0] wd_pair;
    logic          wd_start;
    logic [DW-1:0] wd_b0, wd_b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rv       <= 1'b0;
            r_pair   <= '0;
            r_start  <= 1'b0;
            wa_vld   <= 1'b0;
            wa_pair  <= '0;
            wa_start <= 1'b0;
            wd_vld   <= 1'b0;
            wd_pair  <= '0;
            wd_start <= 1'b0;
            wd_b0    <= '0;
            wd_b1    <= '0;
        end else begin
            rv       <= rd_ok;
            r_pair   <= in_pair;
            r_start  <= in_start;
            wa_vld   <= wr_ok;
            wa_pair  <= in_pair;
            wa_start <= in_start;
            wd_vld   <= wa_vld;
            wd_pair  <= wa_pair;
            wd_start <= wa_start;
            wd_b0    <= wd_rise;
            wd_b1    <= wd_fall;
        end
    end

    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (wd_vld) begin
            mem[{wd_pair, wd_start}]  <= wd_b0;
            mem[{wd_pair, ~wd_start}] <= wd_b1;
        end
    end

    logic          hit;
    logic [DW-1:0] rd0, rd1;

    always_comb begin
        hit = wd_vld && (wd_pair == r_pair);
        if (hit) begin
            rd0 = (r_start == wd_start)    ? wd_b0 : wd_b1;
            rd1 = ((~r_start) == wd_start) ? wd_b0 : wd_b1;
        end else begin
            rd0 = mem[{r_pair, r_start}];
            rd1 = mem[{r_pair, ~r_start}];
        end
    end

    ddrb2_out_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (rv),
        .in_r    (rd0),
        .in_f    (rd1),
        .out_vld (q_valid),
        .out_r   (q_rise),
        .out_f   (q_fall)
    );

    // R3: write beats are captured only the cycle after an accepted write address
    a_r3_data_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        wd_vld |-> $past(wa_vld));

    // R2: a read is latched only out of a read slot
    a_r2_read_in_rd_slot: assert property (@(posedge clk) disable iff (!rst_n)
        rv |-> ($past(slot) == SLOT_RD));

    // R4: read strobe lasts one cycle
    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        q_valid |=> !q_valid);

    // R4: data follows its address one edge later without retiming
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!OUT_REG && rv) |=> q_valid);

    // R8: outputs quiet while no read is presented
    a_r8_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !q_valid |-> (q_rise == '0 && q_fall == '0));
endmodule

// File: tb/ddrb2_sram_test.sv
module ddrb2_sram_test;
    localparam int DW = 8;
    localparam int AW = 4;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wd_rise = '0, wd_fall = '0;
    logic [DW-1:0] q_rise, q_fall, qn_rise, qn_fall;
    logic          q_valid, qn_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ddrb2_sram #(.DW(DW), .AW(AW), .WIDE(1'b1), .OUT_REG(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
        .wd_rise(wd_rise), .wd_fall(wd_fall),
        .q_rise(q_rise), .q_fall(q_fall), .q_valid(q_valid)
    );

    ddrb2_sram #(.DW(DW), .AW(AW), .WIDE(1'b0), .OUT_REG(1'b1)) uut_n (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
        .wd_rise(wd_rise), .wd_fall(wd_fall),
        .q_rise(qn_rise), .q_fall(qn_fall), .q_valid(qn_valid)
    );

    // {rd, wr, addr, wd_rise, wd_fall, exp_valid, exp_rise, exp_fall}
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 4'h2, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 4'h2, 8'hA1, 8'hB1, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b1, 4'h5, 8'h00, 8'h00, 1'b1, 8'hA1, 8'hB1},
        {1'b1, 1'b0, 4'h3, 8'hC2, 8'hD2, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'hB1, 8'hA1},
        {1'b1, 1'b0, 4'h5, 8'hEE, 8'hFF, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'hC2, 8'hD2},
        {1'b1, 1'b0, 4'h4, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b1, 4'h4, 8'h00, 8'h00, 1'b1, 8'hD2, 8'hC2},
        {1'b0, 1'b1, 4'h4, 8'hE4, 8'hF4, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 4'h0, 8'h11, 8'h22, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 4'h4, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00},
        {1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b1, 8'hE4, 8'hF4},
        {1'b0, 1'b0, 4'h0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00}
    };

    function automatic string row_tag(input int i);
        case (i)
            3:       return "R7 R3 R4 forward";
            5:       return "R5 wrap start1";
            7:       return "R5 R3 stored";
            9:       return "R5 R4 start0";
            10:      return "R2 R8 rd in wr slot";
            13:      return "R2 wr in rd slot";
            default: return "R8 idle";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic [AW-1:0] a,
                         input logic [DW-1:0] r, input logic [DW-1:0] f);
        rd_req  = rd;
        wr_req  = wr;
        addr    = a;
        wd_rise = r;
        wd_fall = f;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(1'b0, 1'b0, '0, '0, '0);
        repeat (2) @(negedge clk);
        chk("R1 reset held", {q_valid, q_rise, q_fall}, '0);
        rst_n = 1'b1;
        chk("R1 narrow reset", {qn_valid, qn_rise, qn_fall}, '0);
    endtask

    initial begin
        do_reset();
        // table: each row drives one edge and checks the sample after it
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][38], VEC[i][37], VEC[i][36:33], VEC[i][32:25], VEC[i][24:17]);
            @(negedge clk);
            chk(row_tag(i), {q_valid, q_rise, q_fall}, {VEC[i][16], VEC[i][15:8], VEC[i][7:0]});
        end

        // directed: narrow-word mapping, output retiming, forwarding in wide mode
        do_reset();
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00); @(negedge clk);  // read slot
        drive(1'b0, 1'b1, 4'h2, 8'h00, 8'h00); @(negedge clk);  // write addr 2
        drive(1'b0, 1'b0, 4'h0, 8'h11, 8'h22); @(negedge clk);  // its beats
        drive(1'b0, 1'b1, 4'h3, 8'h00, 8'h00); @(negedge clk);  // write addr 3
        drive(1'b1, 1'b0, 4'h2, 8'h33, 8'h44); @(negedge clk);  // read addr 2 + beats
        drive(1'b0, 1'b0, 4'h0, 8'h00, 8'h00); @(negedge clk);
        chk("R7 R5 wide forward same burst", {q_valid, q_rise, q_fall}, {1'b1, 8'h44, 8'h33});
        chk("R4 retimed not yet valid", {31'd0, qn_valid}, 32'd0);
        @(negedge clk);
        chk("R6 R4 narrow distinct burst", {qn_valid, qn_rise, qn_fall}, {1'b1, 8'h11, 8'h22});
        chk("R4 wide strobe one cycle", {31'd0, q_valid}, 32'd0);
        @(negedge clk);
        chk("R8 narrow idle zero", {qn_valid, qn_rise, qn_fall}, '0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule